// File: doc/BRIEF.md
# Translation Entry Rights Checker

This block turns a translation-buffer entry that the tag search has already picked into a final verdict for one memory access. Each entry covers a pair of adjacent pages, an even one and an odd one, stored as two halves. The block works out the page size, picks the half that holds the address, pulls out that half's flags, and runs the access through a fixed ladder of checks. The result is one of seven result codes. On success it also gives a physical address and the read/write/execute rights of the page.

Requests come in on a valid/ready handshake and leave on a second one, after one register stage. The input side accepts a request when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The output holds steady while `out_valid` is high and `out_ready` is low. Apart from this back-pressure path, the block does not wait on anything, so with `out_ready` held high it accepts one request per cycle.

The caller keeps both page-size inputs in the range 12 to `VA_W-1`.

Top module: `tlbchk`

## Requirements
- R1: The half used is the odd half when virtual address bit [page size] is 1, and the even half when it is 0.
- R2: The page size is `in_global_ps` when `in_fixed` is 1, meaning the hit came from the fixed-size part, and `in_entry_ps` otherwise.
- R3: Page-number bits standing for address bits 12 up to page size minus 1 are cleared before the address is formed.
- R4: Each half holds its fields at these bits: [0] valid, [1] dirty, [3:2] entry level, [4] no-read, [5] no-execute, [6] exact-level, and [8 +: PA_W-12] page number. Access codes are fetch=0, load=1 and store=2. On a hit the first failing check sets the result, in this order:
  - valid is 0: INVALID;
  - fetch with no-execute set: XI;
  - load with no-read set: RI;
  - a privilege violation: PE;
  - store with dirty clear: DIRTY;
  - no check fails: MATCH.
- R5: A privilege violation is defined by the exact-level bit. With exact-level 0 it is a current level greater than the entry level. With exact-level 1 it is any current level that differs from the entry level.
- R6: On MATCH, `out_pa` is the cleaned page number shifted left by 12, ORed with the virtual address bits below the page size.
- R7: On MATCH, `out_perm` bit 0 (read) is always 1, bit 1 (write) equals dirty, and bit 2 (execute) is the inverse of the effective no-execute bit.
- R8: When `in_wide` is 0, the no-execute, no-read and exact-level bits are taken as 0.
- R9: When `in_hit` is 0, the result is NOMATCH whatever the entry holds.
- R10: Result codes are MATCH=0, NOMATCH=1, INVALID=2, DIRTY=3, XI=4, RI=5 and PE=6. `out_pa` and `out_perm` are zero for every result other than MATCH.
- R11: A request is taken on a rising edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` one cycle later. `in_ready` is low only while `out_valid` is high and `out_ready` is low. During such a stall the outputs stay unchanged.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_va | input | VA_W | Virtual address |
| in_acc | input | 2 | Access type: fetch=0, load=1, store=2 |
| in_cur_plv | input | 2 | Current privilege level |
| in_hit | input | 1 | Tag search found the entry |
| in_fixed | input | 1 | Entry lies in the fixed page-size part |
| in_global_ps | input | PS_W | Page size shared by the fixed part |
| in_entry_ps | input | PS_W | Page size stored in the entry |
| in_half_even | input | PA_W-4 | Even-page half of the entry |
| in_half_odd | input | PA_W-4 | Odd-page half of the entry |
| in_wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 3 | Result code |
| out_pa | output | PA_W | Physical address |
| out_perm | output | 3 | Rights: [0] read, [1] write, [2] execute |

## Verification
The bench builds the block with `VA_W=16`, `PA_W=16` and `PS_W=4`. This gives page sizes 12 to 15 and a 4-bit page number. With these sizes, one sweep of 16384 requests walks through every combination of the seven flag bits, access type, current level, mode, hit and fixed-part flag, while the page sizes, address and page number vary along with them. The unused half always carries the inverted flags and page number, so picking the wrong half changes the outcome. A separate stall sequence exercises the back-pressure rules.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_NOMATCH = 3'd1,
    RES_INVALID = 3'd2,
    RES_DIRTY   = 3'd3,
    RES_XI      = 3'd4,
    RES_RI      = 3'd5,
    RES_PE      = 3'd6
  } res_e;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  // field positions inside one entry half
  localparam int BIT_V      = 0;
  localparam int BIT_D      = 1;
  localparam int BIT_PLV    = 2;
  localparam int BIT_NR     = 4;
  localparam int BIT_NX     = 5;
  localparam int BIT_EXACT  = 6;
  localparam int PPN_LSB    = 8;
  localparam int BASE_SHIFT = 12;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  typedef struct packed {
    logic       v;
    logic       d;
    logic [1:0] plv;
    logic       nr;
    logic       nx;
    logic       exact;
  } flags_t;

endpackage

// File: rtl/tlbchk_halfsel.sv
module tlbchk_halfsel #(
  parameter int VA_W   = 48,
  parameter int PS_W   = 6,
  parameter int HALF_W = 44
) (
  input  logic [VA_W-1:0]   va,
  input  logic              from_fixed,
  input  logic [PS_W-1:0]   global_ps,
  input  logic [PS_W-1:0]   entry_ps,
  input  logic [HALF_W-1:0] half_even,
  input  logic [HALF_W-1:0] half_odd,
  output logic [PS_W-1:0]   ps,
  output logic [HALF_W-1:0] half
);
  logic odd;

  always_comb begin
    ps   = from_fixed ? global_ps : entry_ps;
    odd  = |(va & (VA_W'(1) << ps));
    half = odd ? half_odd : half_even;
  end

endmodule

// File: rtl/tlbchk_rights.sv
module tlbchk_rights
  import tlbchk_pkg::*;
(
  input  logic       hit,
  input  logic       wide,
  input  logic [1:0] acc,
  input  logic [1:0] cur_plv,
  input  flags_t     raw,
  output flags_t     eff,
  output res_e       code
);
  logic plv_bad;

  always_comb begin
    eff       = raw;
    eff.nr    = raw.nr & wide;
    eff.nx    = raw.nx & wide;
    eff.exact = raw.exact & wide;

    plv_bad = eff.exact ? (cur_plv != eff.plv) : (cur_plv > eff.plv);

    if (!hit)                          code = RES_NOMATCH;
    else if (!eff.v)                   code = RES_INVALID;
    else if (acc == ACC_FETCH && eff.nx) code = RES_XI;
    else if (acc == ACC_LOAD && eff.nr)  code = RES_RI;
    else if (plv_bad)                  code = RES_PE;
    else if (acc == ACC_STORE && !eff.d) code = RES_DIRTY;
    else                               code = RES_MATCH;
  end

  always_comb begin
    if (hit && !raw.v)
      AST_INVALID_FIRST: assert (code == RES_INVALID); // R4
    if (!wide)
      AST_NARROW_NO_XI_RI: assert (code != RES_XI && code != RES_RI); // R8
  end

endmodule

// File: rtl/tlbchk_compose.sv
module tlbchk_compose
  import tlbchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PS_W = 6,
  localparam int PPN_W = PA_W - BASE_SHIFT
) (
  input  logic [VA_W-1:0]  va,
  input  logic [PS_W-1:0]  ps,
  input  logic [PPN_W-1:0] ppn,
  input  logic             dirty,
  input  logic             no_exec,
  input  logic             is_match,
  output logic [PA_W-1:0]  pa,
  output logic [2:0]       perm
);
  logic [PPN_W-1:0] ppn_kept;
  logic [PA_W-1:0]  offset;

  // page-number bits below the page size are software bits
  for (genvar gi = 0; gi < PPN_W; gi++) begin : g_ppn
    assign ppn_kept[gi] = ppn[gi] & (int'(ps) <= gi + BASE_SHIFT);
  end

  for (genvar gi = 0; gi < PA_W; gi++) begin : g_off
    if (gi < VA_W) begin : g_src
      assign offset[gi] = va[gi] & (gi < int'(ps));
    end else begin : g_zero
      assign offset[gi] = 1'b0;
    end
  end

  always_comb begin
    pa   = '0;
    perm = '0;
    if (is_match) begin
      pa           = {ppn_kept, {BASE_SHIFT{1'b0}}} | offset;
      perm[PERM_R] = 1'b1;
      perm[PERM_W] = dirty;
      perm[PERM_X] = !no_exec;
    end
  end

endmodule

// File: rtl/tlbchk.sv
module tlbchk
  import tlbchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PS_W = 6,
  localparam int PPN_W  = PA_W - BASE_SHIFT,
  localparam int HALF_W = PPN_LSB + PPN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VA_W-1:0]   in_va,
  input  logic [1:0]        in_acc,
  input  logic [1:0]        in_cur_plv,
  input  logic              in_hit,
  input  logic              in_fixed,
  input  logic [PS_W-1:0]   in_global_ps,
  input  logic [PS_W-1:0]   in_entry_ps,
  input  logic [HALF_W-1:0] in_half_even,
  input  logic [HALF_W-1:0] in_half_odd,
  input  logic              in_wide,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_res,
  output logic [PA_W-1:0]   out_pa,
  output logic [2:0]        out_perm
);
  logic [PS_W-1:0]   ps;
  logic [HALF_W-1:0] half;
  flags_t            raw, eff;
  res_e              code;
  logic [PA_W-1:0]   pa_c;
  logic [2:0]        perm_c;
  logic              take;

  tlbchk_halfsel #(.VA_W(VA_W), .PS_W(PS_W), .HALF_W(HALF_W)) u_halfsel (
    .va        (in_va),
    .from_fixed(in_fixed),
    .global_ps (in_global_ps),
    .entry_ps  (in_entry_ps),
    .half_even (in_half_even),
    .half_odd  (in_half_odd),
    .ps        (ps),
    .half      (half)
  );

  always_comb begin
    raw.v     = half[BIT_V];
    raw.d     = half[BIT_D];
    raw.plv   = half[BIT_PLV +: 2];
    raw.nr    = half[BIT_NR];
    raw.nx    = half[BIT_NX];
    raw.exact = half[BIT_EXACT];
  end

  tlbchk_rights u_rights (
    .hit    (in_hit),
    .wide   (in_wide),
    .acc    (in_acc),
    .cur_plv(in_cur_plv),
    .raw    (raw),
    .eff    (eff),
    .code   (code)
  );

  tlbchk_compose #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)) u_compose (
    .va      (in_va),
    .ps      (ps),
    .ppn     (half[PPN_LSB +: PPN_W]),
    .dirty   (eff.d),
    .no_exec (eff.nx),
    .is_match(code == RES_MATCH),
    .pa      (pa_c),
    .perm    (perm_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= RES_NOMATCH;
      out_pa    <= '0;
      out_perm  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_res   <= code;
      out_pa    <= pa_c;
      out_perm  <= perm_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_NOMATCH_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_hit) |=> (out_valid && out_res == RES_NOMATCH)); // R9

  AST_QUIET_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_res != RES_MATCH) |-> (out_pa == '0 && out_perm == '0)); // R10

  AST_READ_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_res == RES_MATCH) |-> out_perm[PERM_R]); // R7

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) &&
                                   $stable(out_pa) && $stable(out_perm))); // R11

endmodule

// File: tb/test_tlbchk.sv
module test_tlbchk;
  localparam int VA_W   = 16;
  localparam int PA_W   = 16;
  localparam int PS_W   = 4;
  localparam int PPN_W  = PA_W - 12;
  localparam int HALF_W = 8 + PPN_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [VA_W-1:0]   in_va = '0;
  logic [1:0]        in_acc = '0;
  logic [1:0]        in_cur_plv = '0;
  logic              in_hit = 1'b0;
  logic              in_fixed = 1'b0;
  logic [PS_W-1:0]   in_global_ps = 4'd12;
  logic [PS_W-1:0]   in_entry_ps = 4'd12;
  logic [HALF_W-1:0] in_half_even = '0;
  logic [HALF_W-1:0] in_half_odd = '0;
  logic              in_wide = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [2:0]        out_res;
  logic [PA_W-1:0]   out_pa;
  logic [2:0]        out_perm;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tlbchk #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)) i_tlbchk (
    .clk, .rst_n, .in_valid, .in_ready, .in_va, .in_acc, .in_cur_plv,
    .in_hit, .in_fixed, .in_global_ps, .in_entry_ps, .in_half_even,
    .in_half_odd, .in_wide, .out_valid, .out_ready, .out_res, .out_pa, .out_perm
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected outcome from the requirements
  function automatic void model(
    input logic [6:0] fl, input logic [PPN_W-1:0] ppn, input logic [VA_W-1:0] va,
    input int ps, input logic [1:0] acc, input logic [1:0] cur,
    input logic wide, input logic hit,
    output logic [2:0] res, output logic [PA_W-1:0] pa, output logic [2:0] perm);
    logic v, d, nr, nx, ex;
    logic [1:0] lvl;
    logic bad;
    int pn;
    v = fl[0]; d = fl[1]; lvl = fl[3:2];
    nr = fl[4] & wide; nx = fl[5] & wide; ex = fl[6] & wide;
    bad = ex ? (cur != lvl) : (cur > lvl);
    if (!hit) res = 3'd1;
    else if (!v) res = 3'd2;
    else if (acc == 2'd0 && nx) res = 3'd4;
    else if (acc == 2'd1 && nr) res = 3'd5;
    else if (bad) res = 3'd6;
    else if (acc == 2'd2 && !d) res = 3'd3;
    else res = 3'd0;
    pa = '0; perm = '0;
    if (res == 3'd0) begin
      pn = int'(ppn) & ~((1 << (ps - 12)) - 1);
      pa = PA_W'((pn << 12) | (int'(va) & ((1 << ps) - 1)));
      perm = {!nx, d, 1'b1};
    end
  endfunction

  task automatic send(input int k);
    logic [6:0] fl;
    logic [PPN_W-1:0] ppn;
    logic [VA_W-1:0] va;
    logic [1:0] acc;
    int eps, gps, ps;
    logic [HALF_W-1:0] sel, other;
    logic [2:0] e_res, e_perm;
    logic [PA_W-1:0] e_pa;
    fl  = k[6:0];
    acc = (k[8:7] == 2'd3) ? 2'd2 : k[8:7];
    eps = 12 + ((k >> 3) & 3);
    gps = 12 + ((k >> 5) & 3);
    va  = VA_W'(k * 40503 + 7);
    ppn = PPN_W'((k * 5) ^ (k >> 4));
    ps  = k[13] ? gps : eps;
    sel   = {ppn, 1'b0, fl};
    other = {~ppn, 1'b0, ~fl};
    in_va = va; in_acc = acc; in_cur_plv = k[10:9]; in_wide = k[11];
    in_hit = k[12]; in_fixed = k[13];
    in_entry_ps = PS_W'(eps); in_global_ps = PS_W'(gps);
    if (va[ps]) begin in_half_odd = sel; in_half_even = other; end
    else begin in_half_even = sel; in_half_odd = other; end
    in_valid = 1'b1;
    model(fl, ppn, va, ps, acc, k[10:9], k[11], k[12], e_res, e_pa, e_perm);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 out_valid", 32'(out_valid), 32'd1);
    check("R4/R5/R8/R9 result code", 32'(out_res), 32'(e_res));
    check("R1/R2/R3/R6/R10 address", 32'(out_pa), 32'(e_pa));
    check("R7/R10 rights", 32'(out_perm), 32'(e_perm));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 out_valid after reset", 32'(out_valid), 32'd0);
    check("R12 in_ready after reset", 32'(in_ready), 32'd1);

    for (int k = 0; k < 16384; k++) send(k);

    @(negedge clk);
    check("R11 idle drains", 32'(out_valid), 32'd0);

    // stall sequence: valid, store, dirty, level 0 -> MATCH
    out_ready = 1'b0;
    in_hit = 1; in_fixed = 0; in_entry_ps = 4'd12; in_wide = 1; in_acc = 2'd2;
    in_cur_plv = 2'd0; in_va = 16'h0123;
    in_half_even = {4'h5, 8'h03}; in_half_odd = {4'h5, 8'h03};
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 first result held", 32'(out_pa), 32'h5123);
    check("R11 in_ready low while stalled", 32'(in_ready), 32'd0);
    in_va = 16'h0456;
    @(posedge clk); @(negedge clk);
    check("R11 stalled pa stable", 32'(out_pa), 32'h5123);
    check("R11 stalled valid", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R11 next result after release", 32'(out_pa), 32'h5456);
    @(posedge clk); @(negedge clk);
    check("R11 empty after drain", 32'(out_valid), 32'd0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule